// File: doc/BRIEF.md
# Header Insertion Engine

This block puts a header of up to 24 bytes in front of every outgoing datagram. The header comes from a byte template that the control processor writes in advance. Four fields in that template can be overwritten per packet: a payload length, a 16-bit ones'-complement checksum, a 16-bit sequence number and a 32-bit timestamp. Software sets the byte offset of each field, switches each one on or off, and chooses whether the length field is one or two bytes wide. One template can therefore serve several layer-4/5 encapsulations.

The payload arrives as a byte stream with a valid/ready handshake and an end-of-packet flag. The checksum covers the payload, so the block works in store-and-forward fashion. It first accepts and buffers the whole payload. It then runs a short pass over the header to add up its patched bytes. After that it sends the header and then the buffered payload on an output byte stream that also has a valid/ready handshake. The sequence number advances once per packet sent.

Top module: `hdr_insert_top`

## Requirements
- R1: After reset, `s_tready` is 1 and `m_tvalid` is 0. All template bytes, the header length, every field enable, every offset and the sequence counter read as zero.
- R2: A register write at address 0..23 stores the template byte with that index. The control registers are: 0x20 header length, 0x21 enables (bit0 length, bit1 checksum, bit2 sequence, bit3 timestamp), 0x22 length offset, 0x23 length width (bit0: 0 gives 1 byte, 1 gives 2 bytes), 0x24 length adjustment, 0x25 checksum offset, 0x26 sequence offset, 0x27 timestamp offset, 0x28 sequence low byte and 0x29 sequence high byte. A header length above 24 is stored as 24.
- R3: The block accepts payload bytes while idle, up to PAY_DEPTH bytes per packet. `m_tvalid` stays low during this fill phase. After the byte carrying `s_tlast` is accepted, `s_tready` stays low until the last output byte has transferred.
- R4: Each output packet holds exactly header-length header bytes, followed by the payload bytes in arrival order. `m_tlast` is set only on the final payload byte.
- R5: When enabled, the length field carries (payload byte count + adjustment) mod 2^16, big-endian. In 1-byte mode only the low byte is written.
- R6: When enabled, the checksum field holds the ones' complement of the 16-bit ones'-complement sum over the header and the payload taken as one byte string. The pairing is big-endian, starting at header byte 0, and a lone last byte is padded with zero. The checksum bytes count as zero in the sum, and every other patched field counts with its final value.
- R7: When enabled, the sequence field carries the 16-bit counter, big-endian. The counter advances by one after each packet's last byte transfers, wraps from 0xFFFF to 0x0000, and can be preset byte by byte through the registers.
- R8: When enabled, the timestamp field carries, big-endian, the value of a 32-bit counter that is zero in the first cycle after reset and counts every clock. The value is the one held in the cycle in which the packet's first payload byte is accepted.
- R9: A disabled field leaves the template bytes unchanged. Field bytes that fall at or beyond the header length are never emitted.
- R10: Where fields overlap, a byte takes its value from the checksum first, then the sequence number, then the timestamp, then the length.
- R11: While `m_tvalid` is high and `m_tready` is low, `m_tdata` and `m_tlast` hold their values. `m_tvalid` stays high from the first header byte to the last payload byte.
- R12: `m_tvalid` first rises header-length + 1 clock edges after the edge that accepts the last payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| s_tvalid | input | 1 | Payload byte valid |
| s_tready | output | 1 | Payload byte accepted when high with valid |
| s_tdata | input | 8 | Payload byte |
| s_tlast | input | 1 | Final payload byte of the packet |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | 8 | Output byte (header, then payload) |
| m_tlast | output | 1 | Final byte of the output packet |

## Verification
Each output packet can only start a fixed number of cycles after its last input byte is accepted: header length plus one edges, which covers the header summing pass and one fold cycle. The bench records the free-running cycle count on the falling edge just before that accepting edge. It then records the count on the falling edge where `m_tvalid` is first seen, and requires the difference to be header length plus two. The timestamp the bench expects is its own cycle count on the falling edge before the first payload byte's accepting edge, because that is the value the counter holds at that edge. Output bytes are taken on falling edges with ready set and are compared only after the packet's last byte has been seen. The sequence value the bench expects advances at that same point.

// File: rtl/hdr_ins_pkg.sv
package hdr_ins_pkg;
    localparam int HDR_MAX_D   = 24;
    localparam int PAY_DEPTH_D = 64;
    localparam int AW          = 6;
    localparam int OFW         = 5;

    localparam logic [AW-1:0] A_HLEN = 6'h20;
    localparam logic [AW-1:0] A_EN   = 6'h21;
    localparam logic [AW-1:0] A_LOFF = 6'h22;
    localparam logic [AW-1:0] A_LW   = 6'h23;
    localparam logic [AW-1:0] A_LADJ = 6'h24;
    localparam logic [AW-1:0] A_COFF = 6'h25;
    localparam logic [AW-1:0] A_SOFF = 6'h26;
    localparam logic [AW-1:0] A_TOFF = 6'h27;
    localparam logic [AW-1:0] A_SEQL = 6'h28;
    localparam logic [AW-1:0] A_SEQH = 6'h29;

    typedef struct packed {
        logic [OFW-1:0] hlen;
        logic           en_len;
        logic           en_csum;
        logic           en_seq;
        logic           en_ts;
        logic [OFW-1:0] len_off;
        logic [OFW-1:0] csum_off;
        logic [OFW-1:0] seq_off;
        logic [OFW-1:0] ts_off;
        logic           len_two;
        logic [7:0]     len_adj;
    } hdr_cfg_t;

    typedef enum logic [2:0] {ST_FILL, ST_SUMH, ST_FOLD, ST_HDR, ST_PAY} emit_st_e;

    // Returns {hit, byte}: hit when idx lies inside [off, off+width),
    // byte is the big-endian slice of val at that position.
    function automatic logic [8:0] field_pick(logic [OFW-1:0] idx, logic [OFW-1:0] off,
                                              logic [2:0] width, logic [31:0] val);
        logic [5:0] d;
        logic [2:0] pos;
        logic [4:0] sh;
        d   = {1'b0, idx} - {1'b0, off};
        pos = width - 3'd1 - d[2:0];
        sh  = {pos[1:0], 3'b000};
        return {(d < {3'b000, width}), 8'(val >> sh)};
    endfunction

    // End-around-carry fold of a 32-bit raw sum to 16 bits.
    function automatic logic [15:0] ones_fold(logic [31:0] s);
        logic [16:0] a;
        logic [16:0] b;
        a = {1'b0, s[15:0]} + {1'b0, s[31:16]};
        b = {1'b0, a[15:0]} + {16'h0, a[16]};
        return b[15:0];
    endfunction
endpackage

// File: rtl/hdr_cfg_regs.sv
module hdr_cfg_regs
    import hdr_ins_pkg::*;
#(
    parameter int HDR_MAX = HDR_MAX_D
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [AW-1:0]           addr,
    input  logic [7:0]              wdata,
    input  logic                    seq_inc,
    output logic [HDR_MAX-1:0][7:0] tmpl,
    output hdr_cfg_t                cfg,
    output logic [15:0]             seq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tmpl <= '0;
        end else if (we && addr < AW'(HDR_MAX)) begin
            tmpl[addr[OFW-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (addr)
                A_HLEN: cfg.hlen <= (wdata > 8'(HDR_MAX)) ? OFW'(HDR_MAX) : wdata[OFW-1:0];
                A_EN:   {cfg.en_ts, cfg.en_seq, cfg.en_csum, cfg.en_len} <= wdata[3:0];
                A_LOFF: cfg.len_off  <= wdata[OFW-1:0];
                A_LW:   cfg.len_two  <= wdata[0];
                A_LADJ: cfg.len_adj  <= wdata;
                A_COFF: cfg.csum_off <= wdata[OFW-1:0];
                A_SOFF: cfg.seq_off  <= wdata[OFW-1:0];
                A_TOFF: cfg.ts_off   <= wdata[OFW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq <= '0;
        end else if (we && addr == A_SEQL) begin
            seq[7:0] <= wdata;
        end else if (we && addr == A_SEQH) begin
            seq[15:8] <= wdata;
        end else if (seq_inc) begin
            seq <= seq + 16'd1;
        end
    end
endmodule

// File: rtl/hdr_pay_buf.sv
module hdr_pay_buf
    import hdr_ins_pkg::*;
#(
    parameter int PAY_DEPTH = PAY_DEPTH_D,
    localparam int PW = $clog2(PAY_DEPTH),
    localparam int CW = $clog2(PAY_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr,
    input  logic [7:0]    din,
    input  logic          hpar,
    input  logic [PW-1:0] rd_idx,
    input  logic [31:0]   ts_now,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] cnt,
    output logic [31:0]   sum,
    output logic [31:0]   ts_lat
);
    logic [7:0] mem [PAY_DEPTH];
    logic       even_pos;

    // Payload byte k sits at string position hlen+k; even positions are high bytes.
    assign even_pos = ~(hpar ^ cnt[0]);
    assign rd_data  = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (wr) mem[cnt[PW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            sum <= '0;
        end else if (wr) begin
            cnt <= cnt + CW'(1);
            sum <= sum + (even_pos ? {16'h0, din, 8'h00} : {24'h0, din});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_lat <= '0;
        end else if (wr && cnt == '0) begin
            ts_lat <= ts_now;
        end
    end
endmodule

// File: rtl/hdr_emit.sv
module hdr_emit
    import hdr_ins_pkg::*;
#(
    parameter int HDR_MAX   = HDR_MAX_D,
    parameter int PAY_DEPTH = PAY_DEPTH_D,
    localparam int PW = $clog2(PAY_DEPTH),
    localparam int CW = $clog2(PAY_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  hdr_cfg_t                cfg,
    input  logic [HDR_MAX-1:0][7:0] tmpl,
    input  logic [15:0]             seq,
    input  logic [31:0]             ts_lat,
    input  logic [CW-1:0]           cnt,
    input  logic [31:0]             pay_sum,
    input  logic [7:0]              rd_data,
    input  logic                    s_tvalid,
    input  logic                    s_tlast,
    input  logic                    m_tready,
    output logic                    s_tready,
    output logic                    wr,
    output logic                    clr,
    output logic                    seq_inc,
    output logic [PW-1:0]           rd_idx,
    output logic                    m_tvalid,
    output logic [7:0]              m_tdata,
    output logic                    m_tlast
);
    emit_st_e       st;
    logic [OFW-1:0] idx;
    logic [PW-1:0]  ridx;
    logic [31:0]    hacc;
    logic [15:0]    csum_q;
    logic [7:0]     hb;
    logic [8:0]     pk;
    logic [15:0]    lenv;
    logic [15:0]    cval;
    logic           done;

    // Patched header byte at idx; lowest priority applied first.
    always_comb begin
        lenv = 16'(cnt) + {8'h00, cfg.len_adj};
        cval = (st == ST_HDR) ? csum_q : 16'h0000;
        hb   = tmpl[idx];
        pk   = field_pick(idx, cfg.len_off, cfg.len_two ? 3'd2 : 3'd1, {16'h0, lenv});
        if (cfg.en_len && pk[8]) hb = pk[7:0];
        pk   = field_pick(idx, cfg.ts_off, 3'd4, ts_lat);
        if (cfg.en_ts && pk[8]) hb = pk[7:0];
        pk   = field_pick(idx, cfg.seq_off, 3'd2, {16'h0, seq});
        if (cfg.en_seq && pk[8]) hb = pk[7:0];
        pk   = field_pick(idx, cfg.csum_off, 3'd2, {16'h0, cval});
        if (cfg.en_csum && pk[8]) hb = pk[7:0];
    end

    assign s_tready = (st == ST_FILL) && (cnt < CW'(PAY_DEPTH));
    assign wr       = s_tvalid && s_tready;
    assign m_tvalid = (st == ST_HDR) || (st == ST_PAY);
    assign m_tdata  = (st == ST_HDR) ? hb : rd_data;
    assign m_tlast  = (st == ST_PAY) && ({1'b0, ridx} == cnt - CW'(1));
    assign done     = m_tlast && m_tready;
    assign clr      = done;
    assign seq_inc  = done;
    assign rd_idx   = ridx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_FILL;
            idx    <= '0;
            ridx   <= '0;
            hacc   <= '0;
            csum_q <= '0;
        end else begin
            case (st)
                ST_FILL: if (wr && s_tlast) st <= (cfg.hlen == '0) ? ST_FOLD : ST_SUMH;
                ST_SUMH: begin
                    hacc <= hacc + (idx[0] ? {24'h0, hb} : {16'h0, hb, 8'h00});
                    if (idx == cfg.hlen - OFW'(1)) begin
                        idx <= '0;
                        st  <= ST_FOLD;
                    end else begin
                        idx <= idx + OFW'(1);
                    end
                end
                ST_FOLD: begin
                    csum_q <= ~ones_fold(hacc + pay_sum);
                    st     <= (cfg.hlen == '0) ? ST_PAY : ST_HDR;
                end
                ST_HDR: if (m_tready) begin
                    if (idx == cfg.hlen - OFW'(1)) begin
                        idx <= '0;
                        st  <= ST_PAY;
                    end else begin
                        idx <= idx + OFW'(1);
                    end
                end
                ST_PAY: if (m_tready) begin
                    if (m_tlast) begin
                        st   <= ST_FILL;
                        ridx <= '0;
                        hacc <= '0;
                    end else begin
                        ridx <= ridx + PW'(1);
                    end
                end
                default: st <= ST_FILL;
            endcase
        end
    end
endmodule

// File: rtl/hdr_insert_top.sv
module hdr_insert_top
    import hdr_ins_pkg::*;
#(
    parameter int HDR_MAX   = HDR_MAX_D,
    parameter int PAY_DEPTH = PAY_DEPTH_D,
    localparam int PW = $clog2(PAY_DEPTH),
    localparam int CW = $clog2(PAY_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [7:0]    cfg_wdata,
    input  logic          s_tvalid,
    output logic          s_tready,
    input  logic [7:0]    s_tdata,
    input  logic          s_tlast,
    output logic          m_tvalid,
    input  logic          m_tready,
    output logic [7:0]    m_tdata,
    output logic          m_tlast
);
    hdr_cfg_t                cfg;
    logic [HDR_MAX-1:0][7:0] tmpl;
    logic [15:0]             seq_w;
    logic                    seq_inc;
    logic                    wr;
    logic                    clr;
    logic [PW-1:0]           rd_idx;
    logic [7:0]              rd_data;
    logic [CW-1:0]           cnt;
    logic [31:0]             pay_sum;
    logic [31:0]             ts_lat;
    logic [31:0]             tsc;

    always_ff @(posedge clk) begin
        if (rst) tsc <= '0;
        else     tsc <= tsc + 32'd1;
    end

    hdr_cfg_regs #(.HDR_MAX(HDR_MAX)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .seq_inc(seq_inc), .tmpl(tmpl), .cfg(cfg), .seq(seq_w)
    );

    hdr_pay_buf #(.PAY_DEPTH(PAY_DEPTH)) u_buf (
        .clk(clk), .rst(rst), .clr(clr), .wr(wr), .din(s_tdata), .hpar(cfg.hlen[0]),
        .rd_idx(rd_idx), .ts_now(tsc), .rd_data(rd_data), .cnt(cnt), .sum(pay_sum),
        .ts_lat(ts_lat)
    );

    hdr_emit #(.HDR_MAX(HDR_MAX), .PAY_DEPTH(PAY_DEPTH)) u_emit (
        .clk(clk), .rst(rst), .cfg(cfg), .tmpl(tmpl), .seq(seq_w), .ts_lat(ts_lat),
        .cnt(cnt), .pay_sum(pay_sum), .rd_data(rd_data), .s_tvalid(s_tvalid),
        .s_tlast(s_tlast), .m_tready(m_tready), .s_tready(s_tready), .wr(wr),
        .clr(clr), .seq_inc(seq_inc), .rd_idx(rd_idx), .m_tvalid(m_tvalid),
        .m_tdata(m_tdata), .m_tlast(m_tlast)
    );
endmodule

// File: rtl/hdr_insert_chk.sv
module hdr_insert_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic        s_tvalid,
    input logic        s_tready,
    input logic        s_tlast,
    input logic        m_tvalid,
    input logic        m_tready,
    input logic [7:0]  m_tdata,
    input logic        m_tlast,
    input logic [15:0] seq
);
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
        s_tready |-> !m_tvalid);

    p_close_r3: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tready && s_tlast) |=> !s_tready);

    p_reopen_r4: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tready && m_tlast) |=> (s_tready && !m_tvalid));

    p_seq_step_r7: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tready && m_tlast && !cfg_we) |=> (seq == $past(seq) + 16'd1));
endmodule

bind hdr_insert_top hdr_insert_chk u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_tlast(s_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tlast(m_tlast), .seq(seq_w)
);

// File: tb/tb_hdr_insert_top.sv
`timescale 1ns/1ps
module tb_hdr_insert_top;
    import hdr_ins_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       s_tvalid = 1'b0;
    logic       s_tready;
    logic [7:0] s_tdata = '0;
    logic       s_tlast = 1'b0;
    logic       m_tvalid;
    logic       m_tready = 1'b1;
    logic [7:0] m_tdata;
    logic       m_tlast;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic [7:0]  tm [24];
    logic [7:0]  pay [64];
    logic [7:0]  ex [96];
    logic [7:0]  got [96];
    int          exn, got_n, plen_m, hl_m, lo_m, co_m, so_m, to_m, adj_m;
    bit          l2_m, bp_m, gap_bad, fill_bad;
    logic [3:0]  en_m;
    logic [15:0] seq_m;
    logic [31:0] ts_m;
    int          c0, first_cyc;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    hdr_insert_top dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
    );

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_cfg(int hl, logic [3:0] en, int lo, bit l2, int adj, int co, int so, int to);
        wr(A_HLEN, 8'(hl)); wr(A_EN, {4'h0, en}); wr(A_LOFF, 8'(lo)); wr(A_LW, {7'h0, l2});
        wr(A_LADJ, 8'(adj)); wr(A_COFF, 8'(co)); wr(A_SOFF, 8'(so)); wr(A_TOFF, 8'(to));
        hl_m = (hl > 24) ? 24 : hl; en_m = en; lo_m = lo; l2_m = l2; adj_m = adj;
        co_m = co; so_m = so; to_m = to;
    endtask

    task automatic send_pkt();
        for (int k = 0; k < plen_m; k++) begin
            @(negedge clk);
            s_tvalid = 1'b1; s_tdata = pay[k]; s_tlast = (k == plen_m - 1);
            #1;
            if (m_tvalid) fill_bad = 1'b1;
            while (!s_tready) begin
                @(negedge clk); #1;
            end
            if (k == 0) ts_m = 32'(cyc);
            if (k == plen_m - 1) c0 = cyc;
        end
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0;
    endtask

    task automatic collect_pkt();
        bit started = 1'b0;
        bit fin = 1'b0;
        got_n = 0;
        while (!fin) begin
            @(negedge clk);
            m_tready = bp_m ? (cyc % 3 != 0) : 1'b1;
            #1;
            if (m_tvalid) begin
                if (!started) begin first_cyc = cyc; started = 1'b1; end
                if (s_tready) fill_bad = 1'b1;
                if (m_tready) begin
                    if (got_n < 96) got[got_n] = m_tdata;
                    got_n++;
                    if (m_tlast) fin = 1'b1;
                end
            end else if (started) begin
                gap_bad = 1'b1;
            end
        end
    endtask

    task automatic build_exp();
        logic [31:0] acc;
        logic [31:0] fs;
        logic [15:0] cs;
        logic [15:0] lenv;
        int lw;
        lenv = 16'(plen_m + adj_m);
        lw = l2_m ? 2 : 1;
        for (int i = 0; i < hl_m; i++) begin
            logic [7:0] b;
            int d;
            b = tm[i];
            d = i - lo_m; if (en_m[0] && d >= 0 && d < lw) b = 8'(lenv >> (8 * (lw - 1 - d)));
            d = i - to_m; if (en_m[3] && d >= 0 && d < 4)  b = 8'(ts_m >> (8 * (3 - d)));
            d = i - so_m; if (en_m[2] && d >= 0 && d < 2)  b = 8'(seq_m >> (8 * (1 - d)));
            d = i - co_m; if (en_m[1] && d >= 0 && d < 2)  b = 8'h00;
            ex[i] = b;
        end
        for (int k = 0; k < plen_m; k++) ex[hl_m + k] = pay[k];
        exn = hl_m + plen_m;
        acc = 0;
        for (int g = 0; g < exn; g++)
            acc = acc + ((g % 2 == 0) ? {16'h0, ex[g], 8'h00} : {24'h0, ex[g]});
        fs = {16'h0, acc[15:0]} + {16'h0, acc[31:16]};
        fs = {16'h0, fs[15:0]} + {16'h0, fs[31:16]};
        cs = ~fs[15:0];
        for (int i = 0; i < hl_m; i++) begin
            int d;
            d = i - co_m;
            if (en_m[1] && d >= 0 && d < 2) ex[i] = (d == 0) ? cs[15:8] : cs[7:0];
        end
    endtask

    task automatic run_pkt(int plen, int seed, bit bp, string req);
        int mism;
        plen_m = plen; bp_m = bp; gap_bad = 1'b0; fill_bad = 1'b0;
        for (int k = 0; k < plen; k++) pay[k] = 8'(seed * 37 + k * 13 + 5);
        fork
            send_pkt();
            collect_pkt();
        join
        build_exp();
        mism = -1;
        for (int g = 0; g < exn && g < got_n; g++)
            if (got[g] !== ex[g] && mism < 0) mism = g;
        chk(got_n == exn, req, "packet length", got_n, exn);
        chk(mism < 0, req, $sformatf("byte %0d", mism), (mism < 0) ? 0 : int'(got[mism]),
            (mism < 0) ? 0 : int'(ex[mism]));
        chk(first_cyc - c0 == hl_m + 2, "R12", "cycles to first output", first_cyc - c0, hl_m + 2);
        chk(!gap_bad, "R11", "valid gap inside packet", gap_bad, 0);
        chk(!fill_bad, "R3", "input and output overlap", fill_bad, 0);
        seq_m = seq_m + 16'd1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 24; i++) tm[i] = 8'h00;
        seq_m = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(s_tready == 1'b1, "R1", "s_tready after reset", s_tready, 1);
        chk(m_tvalid == 1'b0, "R1", "m_tvalid after reset", m_tvalid, 0);

        // R1: zero template and zero sequence counter
        set_cfg(8, 4'b0100, 0, 1'b0, 0, 0, 3, 0);
        run_pkt(5, 1, 1'b0, "R1");

        for (int i = 0; i < 24; i++) begin
            tm[i] = 8'(i * 17 + 3);
            wr(6'(i), tm[i]);
        end

        // R4: sweep every header length with all fields on
        for (int hl = 0; hl <= 24; hl++) begin
            set_cfg(hl, 4'b1111, 0, 1'b1, 4, 8, 2, 4);
            run_pkt(1 + (hl * 11) % 64, hl, bit'(hl % 2), "R4");
        end

        // R9: every enable combination
        for (int m = 0; m < 16; m++) begin
            set_cfg(16, 4'(m), 0, 1'b1, 3, 8, 2, 4);
            run_pkt(7 + m, 40 + m, bit'(m % 2), "R9");
        end
        // R9: timestamp clipped by header end
        set_cfg(6, 4'b1000, 0, 1'b0, 0, 0, 0, 4);
        run_pkt(3, 60, 1'b0, "R9");

        // R5: one-byte length with adjustment, full-depth payload (R3)
        set_cfg(4, 4'b0001, 1, 1'b0, 200, 0, 0, 0);
        run_pkt(64, 61, 1'b1, "R5");
        run_pkt(64, 62, 1'b0, "R3");

        // R6: odd header and odd payload lengths
        set_cfg(7, 4'b0010, 0, 1'b0, 0, 0, 0, 0);
        run_pkt(9, 63, 1'b0, "R6");
        set_cfg(9, 4'b1110, 0, 1'b0, 0, 5, 1, 1);
        run_pkt(2, 64, 1'b1, "R6");

        // R10: overlapping fields
        set_cfg(8, 4'b1111, 0, 1'b1, 0, 2, 1, 0);
        run_pkt(6, 65, 1'b0, "R10");

        // R7: preset and wrap
        wr(A_SEQL, 8'hFE); wr(A_SEQH, 8'hFF); seq_m = 16'hFFFE;
        set_cfg(4, 4'b0100, 0, 1'b0, 0, 0, 1, 0);
        for (int n = 0; n < 3; n++) run_pkt(4, 70 + n, 1'b0, "R7");

        // R8: timestamp after idle gap
        repeat (37) @(negedge clk);
        set_cfg(6, 4'b1000, 0, 1'b0, 0, 0, 0, 1);
        run_pkt(10, 80, 1'b1, "R8");

        // R2: header length above limit is held at 24
        set_cfg(30, 4'b0000, 0, 1'b0, 0, 0, 0, 0);
        run_pkt(3, 81, 1'b0, "R2");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule